// File: doc/BRIEF.md
# Branch and Stack Sequencer

This block owns the program counter and stack pointer of a small 8-bit processor. A decoder hands it one flow-control command at a time. Each command comes with the flag byte, a condition select, and the B counter or a word to push. The block then performs any operand fetches and stack transfers over a byte-wide memory port. It updates PC and SP and pulses a completion strobe. On that strobe it also reports how many extra clock cycles the command costs when its branch is taken.

When a command is presented, PC already points at the byte after the opcode. A 16-bit stack word always occupies two byte cycles. The low byte sits at SP and the high byte at SP+1. Memory reads are combinational: the read data answers the address in the same cycle. Writes take effect at the clock edge. Opcode decoding, the ALU and interrupt handling are outside the block.

Top module: `branch_stack_seq`

## Requirements
- R1: After reset, PC equals RESET_PC, SP equals RESET_SP, and busy, done, halted, extra_cyc and both memory strobes are low.
- R2: Command codes are 0 rel, 1 rel-if, 2 dec-B-rel, 3 jump, 4 jump-if, 5 call, 6 call-if, 7 return, 8 return-if, 9 restart, 10 push, 11 pop, 12 swap-top, 13 halt; 14 and 15 are spare. A conditional command is taken when flags[cond_sel[2:0]] equals cond_sel[3], with flag Z at bit 6, C at bit 0, P/V at bit 2 and S at bit 7.
- R3: A taken relative command reads one signed offset byte at PC and sets PC to PC+1+offset, with extra_cyc 5. A relative command that is not taken sets PC to PC+1 with no memory read and extra_cyc 0.
- R4: dec-B-rel reports b_out = b_in-1 (modulo 256) and branches as in R3 only when that result is nonzero.
- R5: A taken jump loads PC with the little-endian word at PC, PC+1, with extra_cyc 0. A jump or call that is not taken sets PC to PC+2.
- R6: A taken call fetches its target and lowers SP by 2. It then writes PC+2 (low byte at the new SP, high byte at SP+1), loads PC with the target and reports extra_cyc 7. Memory writes only ever address SP or SP+1.
- R7: A taken return loads PC from the word at SP, raises SP by 2 and reports extra_cyc 6. A return-if whose condition is false changes nothing and makes no memory access.
- R8: A restart pushes the current PC as a call does and loads PC with vec*8, with extra_cyc 0.
- R9: Push stores push_data as a stack word after lowering SP by 2. Pop reads the top word into pop_data and raises SP by 2. SP only ever steps by 2.
- R10: swap-top puts the old top word on pop_data, writes push_data in its place, and leaves SP unchanged.
- R11: Halt sets PC to PC-1 and sets halted. The next accepted command clears halted.
- R12: start is accepted only while busy is low. The two memory strobes are never high together and are both low while not busy. done is high for the cycle in which the command's results are final.
- R13: Spare codes 14 and 15 complete with no change to PC, SP, b_out or pop_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, taken when not busy |
| cmd | input | 4 | Command code |
| cond_sel | input | 4 | Flag index (2:0) and required polarity (3) |
| flags | input | 8 | Flag register |
| b_in | input | 8 | B counter value for dec-B-rel |
| vec | input | 3 | Restart vector index |
| push_data | input | 16 | Word for push and swap-top |
| mem_addr | output | 16 | Byte address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, same cycle |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| b_out | output | 8 | Decremented B counter |
| pop_data | output | 16 | Last word popped or swapped out |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command complete |
| extra_cyc | output | 3 | Extra cycles of a taken branch, valid with done |
| halted | output | 1 | Halt status |

## Verification
A wrong SP or a misordered byte pair shows up at the memory port within one or two cycles. The write address then leaves {SP, SP+1}, or a return later lands on a swapped PC. A wrong condition decode or a bad offset sign becomes visible on PC at the very next done strobe. A stuck busy state shows as a missing done. The scoreboard tracks PC, SP and the stack contents across the whole command chain. Because of that, an error in one command also corrupts the expected values of every later one.

// File: rtl/branch_stack_seq.sv
module branch_stack_seq #(
  parameter logic [15:0] RESET_PC = 16'h0000,
  parameter logic [15:0] RESET_SP = 16'hFFFE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [3:0]  cmd,
  input  logic [3:0]  cond_sel,
  input  logic [7:0]  flags,
  input  logic [7:0]  b_in,
  input  logic [2:0]  vec,
  input  logic [15:0] push_data,
  output logic [15:0] mem_addr,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  output logic [15:0] pc,
  output logic [15:0] sp,
  output logic [7:0]  b_out,
  output logic [15:0] pop_data,
  output logic        busy,
  output logic        done,
  output logic [2:0]  extra_cyc,
  output logic        halted
);
  localparam logic [3:0] C_REL = 4'd0, C_RELC = 4'd1, C_DECB = 4'd2, C_JP = 4'd3,
                         C_JPC = 4'd4, C_CALL = 4'd5, C_CALLC = 4'd6, C_RET = 4'd7,
                         C_RETC = 4'd8, C_RST = 4'd9, C_PUSH = 4'd10, C_POP = 4'd11,
                         C_SWAP = 4'd12, C_HALT = 4'd13;
  localparam logic [2:0] X_REL = 3'd5, X_RET = 3'd6, X_CALL = 3'd7;

  typedef enum logic [2:0] {S_IDLE, S_OFS, S_TL, S_TH, S_PL, S_PH, S_WL, S_WH} st_t;

  st_t         st;
  logic [3:0]  cq;
  logic [7:0]  lo_q;
  logic [15:0] tgt_q, wd_q;
  logic        cond_ok;
  logic [7:0]  b_dec;
  logic [15:0] word_in;

  assign cond_ok = (flags[cond_sel[2:0]] == cond_sel[3]);
  assign b_dec   = b_in - 8'd1;
  assign word_in = {mem_rdata, lo_q};
  assign busy    = (st != S_IDLE);

  always_comb begin
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_addr  = pc;
    mem_wdata = 8'h00;
    case (st)
      S_OFS, S_TL: mem_rd = 1'b1;
      S_TH: begin mem_rd = 1'b1; mem_addr = pc + 16'd1; end
      S_PL: begin mem_rd = 1'b1; mem_addr = sp; end
      S_PH: begin mem_rd = 1'b1; mem_addr = sp + 16'd1; end
      S_WL: begin mem_wr = 1'b1; mem_addr = sp; mem_wdata = wd_q[7:0]; end
      S_WH: begin mem_wr = 1'b1; mem_addr = sp + 16'd1; mem_wdata = wd_q[15:8]; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cq <= 4'd0;
      lo_q <= 8'h00;
      tgt_q <= 16'h0000;
      wd_q <= 16'h0000;
      pc <= RESET_PC;
      sp <= RESET_SP;
      b_out <= 8'h00;
      pop_data <= 16'h0000;
      done <= 1'b0;
      extra_cyc <= 3'd0;
      halted <= 1'b0;
    end else begin
      done <= 1'b0;
      extra_cyc <= 3'd0;
      case (st)
        S_IDLE: if (start) begin
          cq <= cmd;
          halted <= 1'b0;
          case (cmd)
            C_REL, C_RELC, C_DECB: begin
              if (cmd == C_DECB) b_out <= b_dec;
              if (cmd == C_REL || (cmd == C_RELC && cond_ok) || (cmd == C_DECB && b_dec != 8'd0))
                st <= S_OFS;
              else begin
                pc <= pc + 16'd1;
                done <= 1'b1;
              end
            end
            C_JP, C_JPC, C_CALL, C_CALLC: begin
              if (cmd == C_JP || cmd == C_CALL || cond_ok)
                st <= S_TL;
              else begin
                pc <= pc + 16'd2;
                done <= 1'b1;
              end
            end
            C_RET, C_RETC: begin
              if (cmd == C_RET || cond_ok) st <= S_PL;
              else done <= 1'b1;
            end
            C_RST: begin
              tgt_q <= {10'd0, vec, 3'b000};
              wd_q <= pc;
              sp <= sp - 16'd2;
              st <= S_WL;
            end
            C_PUSH: begin
              wd_q <= push_data;
              sp <= sp - 16'd2;
              st <= S_WL;
            end
            C_POP: st <= S_PL;
            C_SWAP: begin
              wd_q <= push_data;
              st <= S_PL;
            end
            C_HALT: begin
              pc <= pc - 16'd1;
              halted <= 1'b1;
              done <= 1'b1;
            end
            default: done <= 1'b1;
          endcase
        end
        S_OFS: begin
          pc <= pc + 16'd1 + {{8{mem_rdata[7]}}, mem_rdata};
          extra_cyc <= X_REL;
          done <= 1'b1;
          st <= S_IDLE;
        end
        S_TL: begin
          lo_q <= mem_rdata;
          st <= S_TH;
        end
        S_TH: begin
          if (cq == C_JP || cq == C_JPC) begin
            pc <= word_in;
            done <= 1'b1;
            st <= S_IDLE;
          end else begin
            tgt_q <= word_in;
            wd_q <= pc + 16'd2;
            sp <= sp - 16'd2;
            st <= S_WL;
          end
        end
        S_PL: begin
          lo_q <= mem_rdata;
          st <= S_PH;
        end
        S_PH: begin
          if (cq == C_SWAP) begin
            pop_data <= word_in;
            st <= S_WL;
          end else begin
            if (cq == C_POP) pop_data <= word_in;
            else begin
              pc <= word_in;
              extra_cyc <= X_RET;
            end
            sp <= sp + 16'd2;
            done <= 1'b1;
            st <= S_IDLE;
          end
        end
        S_WL: st <= S_WH;
        S_WH: begin
          if (cq == C_CALL || cq == C_CALLC) begin
            pc <= tgt_q;
            extra_cyc <= X_CALL;
          end else if (cq == C_RST) begin
            pc <= tgt_q;
          end
          done <= 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/branch_stack_seq_chk.sv
module branch_stack_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        halted,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic [15:0] mem_addr,
  input logic [15:0] pc,
  input logic [15:0] sp,
  input logic [2:0]  extra_cyc
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R12
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd && !mem_wr)); // R12
  AST_EXTRA_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (extra_cyc != 3'd0) |-> done); // R3
  AST_WRITE_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_addr == sp || mem_addr == sp + 16'd1)); // R6
  AST_SP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sp != $past(sp)) |-> (sp == $past(sp) + 16'd2 || sp == $past(sp) - 16'd2)); // R9
  AST_HALT_BACKUP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> (pc == $past(pc) - 16'd1)); // R11
endmodule

bind branch_stack_seq branch_stack_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .halted(halted),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .pc(pc), .sp(sp),
  .extra_cyc(extra_cyc)
);

// File: tb/sim_branch_stack_seq.sv
module sim_branch_stack_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] PC0 = 16'h0100, SP0 = 16'h0F00;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [3:0] cmd = 4'd0, cond_sel = 4'd0;
  logic [7:0] flags = 8'h00, b_in = 8'h00;
  logic [2:0] vec = 3'd0;
  logic [15:0] push_data = 16'h0000;
  logic [15:0] mem_addr, pc, sp, pop_data;
  logic mem_rd, mem_wr, busy, done, halted;
  logic [7:0] mem_wdata, mem_rdata, b_out;
  logic [2:0] extra_cyc;

  logic [7:0] mem [0:4095];
  assign mem_rdata = mem[mem_addr[11:0]];
  always @(posedge clk) if (mem_wr) mem[mem_addr[11:0]] <= mem_wdata;

  int errors = 0, checks = 0, rd_cnt = 0, cyc = 0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (mem_rd) rd_cnt++;

  branch_stack_seq #(.RESET_PC(PC0), .RESET_SP(SP0)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .cond_sel(cond_sel),
    .flags(flags), .b_in(b_in), .vec(vec), .push_data(push_data),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .pc(pc), .sp(sp), .b_out(b_out), .pop_data(pop_data),
    .busy(busy), .done(done), .extra_cyc(extra_cyc), .halted(halted));

  typedef struct {
    logic [15:0] pc, sp, pop;
    logic [7:0] b;
    logic [2:0] ex;
    logic hl;
    int req;
  } exp_t;
  exp_t q[$];

  logic [15:0] m_pc = PC0, m_sp = SP0, m_pop = 16'h0000;
  logic [7:0] m_b = 8'h00;

  task automatic chk(input int req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // monitor: pops one expected item per completion strobe
  always @(negedge clk) if (rst_n && done) begin
    if (q.size() == 0) chk(12, "unexpected done", 16'd1, 16'd0);
    else begin
      exp_t e;
      e = q.pop_front();
      chk(e.req, "pc", pc, e.pc);
      chk(e.req, "sp", sp, e.sp);
      chk(e.req, "extra_cyc", {13'd0, extra_cyc}, {13'd0, e.ex});
      chk(e.req, "pop_data", pop_data, e.pop);
      chk(e.req, "b_out", {8'd0, b_out}, {8'd0, e.b});
      chk(e.req, "halted", {15'd0, halted}, {15'd0, e.hl});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  function automatic logic [15:0] rdw(input logic [15:0] a);
    return {mem[(a + 16'd1) & 16'h0FFF], mem[a & 16'h0FFF]};
  endfunction

  // driver: computes the expected outcome from the requirements, queues it, issues the command
  task automatic issue(input logic [3:0] c, input logic [3:0] cs, input logic [7:0] fl,
                       input logic [7:0] b, input logic [2:0] v, input logic [15:0] pd,
                       input int req, input bit poke);
    exp_t e;
    logic ok, take;
    logic [7:0] off;
    ok = (fl[cs[2:0]] == cs[3]);
    e.ex = 3'd0; e.hl = 1'b0; e.req = req;
    case (c)
      4'd0, 4'd1, 4'd2: begin
        if (c == 4'd2) m_b = b - 8'd1;
        take = (c == 4'd0) || (c == 4'd1 && ok) || (c == 4'd2 && m_b != 8'd0);
        if (take) begin
          off = mem[m_pc[11:0]];
          m_pc = m_pc + 16'd1 + {{8{off[7]}}, off};
          e.ex = 3'd5;
        end else m_pc = m_pc + 16'd1;
      end
      4'd3, 4'd4: m_pc = (c == 4'd3 || ok) ? rdw(m_pc) : m_pc + 16'd2;
      4'd5, 4'd6: if (c == 4'd5 || ok) begin
        m_sp = m_sp - 16'd2; m_pc = rdw(m_pc); e.ex = 3'd7;
      end else m_pc = m_pc + 16'd2;
      4'd7, 4'd8: if (c == 4'd7 || ok) begin
        m_pc = rdw(m_sp); m_sp = m_sp + 16'd2; e.ex = 3'd6;
      end
      4'd9: begin m_sp = m_sp - 16'd2; m_pc = {10'd0, v, 3'b000}; end
      4'd10: m_sp = m_sp - 16'd2;
      4'd11: begin m_pop = rdw(m_sp); m_sp = m_sp + 16'd2; end
      4'd12: m_pop = rdw(m_sp);
      4'd13: begin m_pc = m_pc - 16'd1; e.hl = 1'b1; end
      default: ;
    endcase
    e.pc = m_pc; e.sp = m_sp; e.pop = m_pop; e.b = m_b;
    q.push_back(e);
    cmd = c; cond_sel = cs; flags = fl; b_in = b; vec = v; push_data = pd;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      cmd = 4'd13; start = 1'b1; // must be ignored while busy (R12)
      checks++;
      if (!busy) begin errors++; $display("FAIL R12 busy: actual=0 expected=1"); end
      @(negedge clk);
      start = 1'b0;
    end
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    int r0;
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    mem[12'h100] = 8'h10;                          // rel +16
    mem[12'h111] = 8'hF0;                          // rel -16
    mem[12'h103] = 8'h00; mem[12'h104] = 8'h02;    // -> 0x0200
    mem[12'h202] = 8'h40; mem[12'h203] = 8'h03;    // -> 0x0340
    mem[12'h341] = 8'h05;                          // rel +5
    mem[12'h347] = 8'h00; mem[12'h348] = 8'h05;    // call 0x0500
    mem[12'h027] = 8'h00; mem[12'h028] = 8'h06;    // jump 0x0600
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(1, "reset pc", pc, PC0);
    chk(1, "reset sp", sp, SP0);
    chk(1, "reset busy/done/halted", {13'd0, busy, done, halted}, 16'd0);
    chk(1, "reset extra/strobes", {11'd0, extra_cyc, mem_rd, mem_wr}, 16'd0);
    issue(4'd0, 4'd0, 8'h00, 8'd0, 3'd0, 16'h0, 3, 0);      // R3 forward
    issue(4'd0, 4'd0, 8'h00, 8'd0, 3'd0, 16'h0, 3, 0);      // R3 backward
    r0 = rd_cnt;
    issue(4'd1, 4'b1110, 8'h00, 8'd0, 3'd0, 16'h0, 3, 0);   // R3 Z set required, not taken
    chk(3, "no read when not taken", r0[15:0], rd_cnt[15:0]);
    issue(4'd4, 4'b1000, 8'h01, 8'd0, 3'd0, 16'h0, 2, 0);   // R2 C set -> taken
    issue(4'd4, 4'b0111, 8'h80, 8'd0, 3'd0, 16'h0, 5, 0);   // R2/R5 S clear required, S=1 -> skip
    issue(4'd4, 4'b1010, 8'h04, 8'd0, 3'd0, 16'h0, 2, 0);   // R2 P/V set -> taken
    issue(4'd2, 4'd0, 8'h00, 8'd1, 3'd0, 16'h0, 4, 0);      // R4 B 1->0 falls through
    issue(4'd2, 4'd0, 8'h00, 8'd0, 3'd0, 16'h0, 4, 0);      // R4 B 0->255 branches
    issue(4'd5, 4'd0, 8'h00, 8'd0, 3'd0, 16'h0, 6, 0);      // R6 call
    chk(6, "return word on stack", rdw(16'h0EFE), 16'h0349);
    issue(4'd6, 4'b1110, 8'h00, 8'd0, 3'd0, 16'h0, 5, 0);   // R5 call-if not taken
    r0 = rd_cnt;
    issue(4'd8, 4'b1000, 8'h00, 8'd0, 3'd0, 16'h0, 7, 0);   // R7 return-if false
    chk(7, "no access on false return", r0[15:0], rd_cnt[15:0]);
    issue(4'd7, 4'd0, 8'h00, 8'd0, 3'd0, 16'h0, 7, 0);      // R7 return
    issue(4'd9, 4'd0, 8'h00, 8'd0, 3'd5, 16'h0, 8, 0);      // R8 restart to 0x28
    chk(8, "restart pushed pc", rdw(16'h0EFE), 16'h0349);
    issue(4'd10, 4'd0, 8'h00, 8'd0, 3'd0, 16'hBEEF, 9, 0);  // R9 push
    chk(9, "pushed low byte at SP", {8'd0, mem[12'hEFC]}, 16'h00EF);
    chk(9, "pushed high byte at SP+1", {8'd0, mem[12'hEFD]}, 16'h00BE);
    issue(4'd12, 4'd0, 8'h00, 8'd0, 3'd0, 16'h1234, 10, 0); // R10 swap top
    chk(10, "swapped-in top word", rdw(16'h0EFC), 16'h1234);
    issue(4'd11, 4'd0, 8'h00, 8'd0, 3'd0, 16'h0, 9, 0);     // R9 pop
    issue(4'd13, 4'd0, 8'h00, 8'd0, 3'd0, 16'h0, 11, 0);    // R11 halt
    issue(4'd14, 4'd0, 8'h00, 8'd0, 3'd0, 16'h0, 13, 0);    // R13 spare, also clears halted (R11)
    issue(4'd3, 4'd0, 8'h00, 8'd0, 3'd0, 16'h0, 12, 1);     // R12 start while busy ignored
    repeat (4) @(negedge clk);
    chk(12, "no stray completion", q.size()[15:0], 16'd0);
    summary();
  end
endmodule